// File: doc/BRIEF.md
# Two-Step Timestamp Capture Queue

This block holds timestamp records for two-step precision time protocol handling until software collects them over a small register interface. Every record has a transmit flag, a port number, a nanosecond stamp field and an 8-bit sub-nanosecond field. An ingress event stores one record. An egress event stores a linked pair of records in one operation. The first record of the pair carries the departure nanoseconds. The second carries the frame identifier that the block assigned to that egress event.

The identifier is split across two fields of the companion record: its upper bits sit in the stamp field and its low byte in the sub-nanosecond field, so software rebuilds it as `(stamp << 8) | sub`. Software reads the control word, then the stamp and the sub-nanosecond words, and pops the head record with a write-one bit. It keeps draining until the valid bit reads 0. A sticky overflow flag records any event that was dropped because the queue had no room. The interrupt output stays high for as long as a record is waiting.

Top module: `ts_capture_fifo`

## Requirements
- R1: After reset the queue is empty, the overflow flag is 0, `irq` is 0, and all three register words read 0.
- R2: An egress event (`ev_valid`=1, `ev_tx`=1) stores two records in order. The first has transmit bit 1 and carries the event's port, nanoseconds and sub-nanosecond byte. The second has transmit bit 0, the same port, stamp = ID >> 8 and sub = ID[7:0].
- R3: The ID of the k-th egress event since reset (counting from 0) is k mod 2^ID_W, which is 0 to 511 by default. Dropped egress events also consume an ID.
- R4: An ingress event (`ev_valid`=1, `ev_tx`=0) stores one record with transmit bit 0 and the event's port, nanoseconds and sub-nanosecond byte.
- R5: Control word (address 0) layout: bit 0 valid, bit 1 overflow, bit 2 transmit flag of the head record, bit 3 next, bits 14:8 port of the head record. The stamp word is at address 1 and the sub-nanosecond word at address 2. Writing 1 to bit 3 of the control word pops the head record. Bit 3 always reads 0.
- R6: While the queue is empty, the valid, transmit, port, stamp and sub fields read 0, and a pop request has no effect.
- R7: An egress event needs 2 free records and an ingress event needs 1. The free count is taken before any pop in the same cycle. An event without room is dropped whole and leaves the stored records unchanged.
- R8: Overflow becomes 1 on any dropped event and stays 1 until a 1 is written to control bit 1. When a drop and a clear fall in the same cycle, the flag stays set.
- R9: `irq` equals the valid bit.
- R10: Records leave in arrival order, and a push and a pop in the same cycle both take effect.
- R11: Writes to addresses 1, 2 and 3, and control writes with bits 1 and 3 both 0, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Timestamp event strobe, one cycle per event |
| ev_tx | input | 1 | 1 = egress event (pair), 0 = ingress event (single) |
| ev_port | input | 7 | Port number of the event |
| ev_nsec | input | 30 | Nanosecond stamp of the event |
| ev_sub | input | 8 | Sub-nanosecond byte of the event |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 stamp, 2 sub) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| irq | output | 1 | High while a record is waiting |

## Verification
The bench builds the block with PAIRS=4, so the queue holds 8 records. Full and nearly-full states are then reached within a few events, including the case of one free slot that admits an ingress record but refuses an egress pair. ID_W stays at its default of 9. The wrap from 511 to 0 is reached by streaming several hundred egress events into the full queue, where they are dropped but still consume identifiers.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

    localparam int TSF_PORT_W  = 7;
    localparam int TSF_STAMP_W = 30;
    localparam int TSF_SUB_W   = 8;
    localparam int TSF_DATA_W  = 32;
    localparam int TSF_IDF_W   = TSF_STAMP_W + TSF_SUB_W;

    localparam int CB_VALID    = 0;
    localparam int CB_OVF      = 1;
    localparam int CB_TX       = 2;
    localparam int CB_NEXT     = 3;
    localparam int CB_PORT_LSB = 8;

    typedef struct packed {
        logic                   is_tx;
        logic [TSF_PORT_W-1:0]  port;
        logic [TSF_STAMP_W-1:0] stamp;
        logic [TSF_SUB_W-1:0]   sub;
    } tsf_entry_t;

    typedef struct packed {
        logic pair;
        logic single;
    } tsf_req_t;

    typedef enum logic [1:0] {
        TSF_REG_CTRL  = 2'd0,
        TSF_REG_STAMP = 2'd1,
        TSF_REG_SUB   = 2'd2,
        TSF_REG_SPARE = 2'd3
    } tsf_reg_e;

    function automatic tsf_entry_t tsf_stamp_entry(
        input logic                   is_tx,
        input logic [TSF_PORT_W-1:0]  port,
        input logic [TSF_STAMP_W-1:0] stamp,
        input logic [TSF_SUB_W-1:0]   sub
    );
        tsf_entry_t e;
        e.is_tx = is_tx;
        e.port  = port;
        e.stamp = stamp;
        e.sub   = sub;
        return e;
    endfunction

    function automatic tsf_entry_t tsf_id_entry(
        input logic [TSF_PORT_W-1:0] port,
        input logic [TSF_IDF_W-1:0]  id
    );
        tsf_entry_t e;
        e.is_tx = 1'b0;
        e.port  = port;
        e.stamp = id[TSF_IDF_W-1:TSF_SUB_W];
        e.sub   = id[TSF_SUB_W-1:0];
        return e;
    endfunction

    function automatic logic [TSF_DATA_W-1:0] tsf_ctrl_word(
        input logic                  valid,
        input logic                  ovf,
        input logic                  is_tx,
        input logic [TSF_PORT_W-1:0] port
    );
        logic [TSF_DATA_W-1:0] w;
        w                            = '0;
        w[CB_VALID]                  = valid;
        w[CB_OVF]                    = ovf;
        w[CB_TX]                     = is_tx;
        w[CB_PORT_LSB +: TSF_PORT_W] = port;
        return w;
    endfunction

endpackage

// File: rtl/tsf_event_builder.sv
module tsf_event_builder
    import tsf_pkg::*;
#(
    parameter int ID_W = 9
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ev_valid,
    input  logic                   ev_tx,
    input  logic [TSF_PORT_W-1:0]  ev_port,
    input  logic [TSF_STAMP_W-1:0] ev_nsec,
    input  logic [TSF_SUB_W-1:0]   ev_sub,
    output tsf_req_t               req,
    output tsf_entry_t             first,
    output tsf_entry_t             second
);

    logic [ID_W-1:0] id_q;

    // identifier advances on every egress event, stored or dropped
    always_ff @(posedge clk) begin
        if (rst) begin
            id_q <= '0;
        end else if (ev_valid && ev_tx) begin
            id_q <= id_q + 1'b1;
        end
    end

    always_comb begin
        req.pair   = ev_valid & ev_tx;
        req.single = ev_valid & ~ev_tx;
        first      = tsf_stamp_entry(ev_tx, ev_port, ev_nsec, ev_sub);
        second     = tsf_id_entry(ev_port, TSF_IDF_W'(id_q));
    end

    initial begin
        assert (ID_W <= TSF_IDF_W)
            else $error("identifier does not fit the companion record");
    end

endmodule

// File: rtl/tsf_store.sv
module tsf_store
    import tsf_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  tsf_req_t         req,
    input  tsf_entry_t       first,
    input  tsf_entry_t       second,
    input  logic             pop,
    output tsf_entry_t       head,
    output logic [CNT_W-1:0] count,
    output logic             drop
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    tsf_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_ptr1;
    logic [CNT_W-1:0] count_q, room;
    logic             take_pair, take_single, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        room        = CNT_W'(DEPTH) - count_q;
        take_pair   = req.pair   && (room >= CNT_W'(2));
        take_single = req.single && (room >= CNT_W'(1));
        drop        = (req.pair & ~take_pair) | (req.single & ~take_single);
        do_pop      = pop && (count_q != '0);
        wr_ptr1     = bump(wr_ptr);
        head        = mem[rd_ptr];
        count       = count_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            if (take_pair) begin
                mem[wr_ptr]  <= first;
                mem[wr_ptr1] <= second;
                wr_ptr       <= bump(wr_ptr1);
            end else if (take_single) begin
                mem[wr_ptr] <= first;
                wr_ptr      <= wr_ptr1;
            end
            if (do_pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            count_q <= count_q + CNT_W'({take_pair, take_single}) - CNT_W'(do_pop);
        end
    end

    // R7: occupancy never passes the capacity
    p_count_bound_r7: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNT_W'(DEPTH));

    // R2: a transmit record leaving always has its companion behind it
    p_pair_intact_r2: assert property (@(posedge clk) disable iff (rst)
        (do_pop && head.is_tx) |-> (count_q >= CNT_W'(2)));

    // R6: a pop on an empty queue leaves it empty
    p_empty_pop_r6: assert property (@(posedge clk) disable iff (rst)
        (pop && count_q == '0 && !req.pair && !req.single) |=> (count_q == '0));

endmodule

// File: rtl/tsf_regs.sv
module tsf_regs
    import tsf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr,
    input  logic [1:0]            reg_addr,
    input  logic [TSF_DATA_W-1:0] reg_wdata,
    input  tsf_entry_t            head,
    input  logic                  nonempty,
    input  logic                  drop,
    output logic                  pop,
    output logic                  irq,
    output logic [TSF_DATA_W-1:0] rdata
);

    tsf_reg_e   addr_e;
    tsf_entry_t vis;
    logic       ctrl_wr, ovf_clr, ovf_q;
    logic       unused_wdata;

    always_comb begin
        addr_e  = tsf_reg_e'(reg_addr);
        ctrl_wr = reg_wr && (addr_e == TSF_REG_CTRL);
        pop     = ctrl_wr && reg_wdata[CB_NEXT];
        ovf_clr = ctrl_wr && reg_wdata[CB_OVF];
        vis     = nonempty ? head : '0;
        irq     = nonempty;
        unique case (addr_e)
            TSF_REG_CTRL:  rdata = tsf_ctrl_word(nonempty, ovf_q, vis.is_tx, vis.port);
            TSF_REG_STAMP: rdata = TSF_DATA_W'(vis.stamp);
            TSF_REG_SUB:   rdata = TSF_DATA_W'(vis.sub);
            default:       rdata = '0;
        endcase
    end

    assign unused_wdata = ^{reg_wdata[31:4], reg_wdata[2], reg_wdata[0]};

    // a drop in the same cycle as a clear keeps the flag set
    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
        end else if (drop) begin
            ovf_q <= 1'b1;
        end else if (ovf_clr) begin
            ovf_q <= 1'b0;
        end
    end

    // R8: flag holds until an explicit clear
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !ovf_clr) |=> ovf_q);

    // R8: every dropped event is recorded
    p_ovf_set_r8: assert property (@(posedge clk) disable iff (rst)
        drop |=> ovf_q);

endmodule

// File: rtl/ts_capture_fifo.sv
module ts_capture_fifo
    import tsf_pkg::*;
#(
    parameter int PAIRS = 16,
    parameter int ID_W  = 9
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ev_valid,
    input  logic                   ev_tx,
    input  logic [TSF_PORT_W-1:0]  ev_port,
    input  logic [TSF_STAMP_W-1:0] ev_nsec,
    input  logic [TSF_SUB_W-1:0]   ev_sub,
    input  logic                   reg_wr,
    input  logic [1:0]             reg_addr,
    input  logic [TSF_DATA_W-1:0]  reg_wdata,
    output logic [TSF_DATA_W-1:0]  reg_rdata,
    output logic                   irq
);

    localparam int DEPTH = 2 * PAIRS;
    localparam int CNT_W = $clog2(DEPTH + 1);

    tsf_req_t         req;
    tsf_entry_t       first, second, head;
    logic [CNT_W-1:0] count;
    logic             drop, pop, nonempty;

    assign nonempty = (count != '0);

    tsf_event_builder #(.ID_W(ID_W)) u_build (
        .clk      (clk),
        .rst      (rst),
        .ev_valid (ev_valid),
        .ev_tx    (ev_tx),
        .ev_port  (ev_port),
        .ev_nsec  (ev_nsec),
        .ev_sub   (ev_sub),
        .req      (req),
        .first    (first),
        .second   (second)
    );

    tsf_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .first  (first),
        .second (second),
        .pop    (pop),
        .head   (head),
        .count  (count),
        .drop   (drop)
    );

    tsf_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .head      (head),
        .nonempty  (nonempty),
        .drop      (drop),
        .pop       (pop),
        .irq       (irq),
        .rdata     (reg_rdata)
    );

    // R9: interrupt tracks the occupancy held in the store
    p_irq_match_r9: assert property (@(posedge clk) disable iff (rst)
        irq == (count != '0));

endmodule

// File: tb/ts_capture_fifo_tb.sv
module ts_capture_fifo_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        ev_valid, ev_tx;
    logic [6:0]  ev_port;
    logic [29:0] ev_nsec;
    logic [7:0]  ev_sub;
    logic        reg_wr;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    int next_id  = 0;

    always #5 clk = ~clk;

    ts_capture_fifo #(.PAIRS(4), .ID_W(9)) u_dut (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_tx(ev_tx),
        .ev_port(ev_port), .ev_nsec(ev_nsec), .ev_sub(ev_sub),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [31:0] cw(input logic v, input logic o, input logic t, input int p);
        return {17'd0, 7'(p), 5'd0, t, o, v};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic chk_head(input string req, input logic [31:0] ec, input int es, input int esub);
        logic [31:0] d;
        rd(2'd0, d); chk(req, "ctrl", d, ec);
        rd(2'd1, d); chk(req, "stamp", d, 32'(es));
        rd(2'd2, d); chk(req, "sub", d, 32'(esub));
        chk(req, "irq", 32'(irq), 32'(ec[0]));
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; reg_addr = 2'd0;
    endtask

    task automatic pop_head();
        wr(2'd0, 32'h8);
    endtask

    // event, optionally with a control write in the same cycle
    task automatic ev_wr(input logic tx, input int port, input int ns, input int sub,
                         input logic do_wr, input logic [31:0] wd);
        @(negedge clk);
        ev_valid = 1'b1; ev_tx = tx; ev_port = 7'(port); ev_nsec = 30'(ns); ev_sub = 8'(sub);
        reg_wr = do_wr; reg_addr = 2'd0; reg_wdata = wd;
        if (tx) next_id = (next_id + 1) % 512;
        @(negedge clk);
        ev_valid = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic ev(input logic tx, input int port, input int ns, input int sub);
        ev_wr(tx, port, ns, sub, 1'b0, '0);
    endtask

    task automatic t_reset();
        chk_head("R1", 32'h0, 0, 0);
        chk("R9", "irq after reset", 32'(irq), 32'h0);
    endtask

    task automatic t_egress();
        int id;
        id = next_id;
        ev(1'b1, 5, 123456, 8'h3c);
        chk_head("R2", cw(1, 0, 1, 5), 123456, 8'h3c);
        pop_head();
        chk_head("R3", cw(1, 0, 0, 5), id >> 8, id & 255);
        pop_head();
        chk_head("R5", 32'h0, 0, 0);
    endtask

    task automatic t_ingress();
        ev(1'b0, 2, 777, 9);
        chk_head("R4", cw(1, 0, 0, 2), 777, 9);
        pop_head();
        chk_head("R9", 32'h0, 0, 0);
    endtask

    task automatic t_order();
        int ia, ic;
        ia = next_id; ev(1'b1, 10, 1000, 1);
        ev(1'b0, 11, 2000, 2);
        ic = next_id; ev(1'b1, 12, 3000, 3);
        chk_head("R10", cw(1, 0, 1, 10), 1000, 1); pop_head();
        chk_head("R10", cw(1, 0, 0, 10), ia >> 8, ia & 255); pop_head();
        chk_head("R10", cw(1, 0, 0, 11), 2000, 2); pop_head();
        chk_head("R10", cw(1, 0, 1, 12), 3000, 3); pop_head();
        chk_head("R10", cw(1, 0, 0, 12), ic >> 8, ic & 255);
        // pop and push in the same cycle
        ev_wr(1'b0, 13, 4000, 4, 1'b1, 32'h8);
        chk_head("R10", cw(1, 0, 0, 13), 4000, 4); pop_head();
        chk_head("R10", 32'h0, 0, 0);
    endtask

    task automatic t_empty_and_ignored();
        pop_head();
        chk_head("R6", 32'h0, 0, 0);
        ev(1'b0, 3, 55, 6);
        chk_head("R6", cw(1, 0, 0, 3), 55, 6);
        wr(2'd1, 32'hffff_ffff);
        wr(2'd2, 32'hffff_ffff);
        wr(2'd3, 32'hffff_ffff);
        wr(2'd0, 32'hffff_fff5);
        chk_head("R11", cw(1, 0, 0, 3), 55, 6);
        pop_head();
        chk_head("R11", 32'h0, 0, 0);
    endtask

    task automatic t_capacity();
        int i1, i2, i3;
        i1 = next_id; ev(1'b1, 1, 100, 1);
        i2 = next_id; ev(1'b1, 2, 200, 2);
        i3 = next_id; ev(1'b1, 3, 300, 3);
        ev(1'b0, 4, 400, 4);                   // 7 of 8 used
        ev(1'b1, 5, 500, 5);                   // pair refused
        chk_head("R8", cw(1, 1, 1, 1), 100, 1);
        ev(1'b0, 6, 600, 6);                   // single fits
        ev(1'b0, 7, 700, 7);                   // full: dropped
        wr(2'd0, 32'h2);
        chk_head("R8", cw(1, 0, 1, 1), 100, 1);
        ev_wr(1'b0, 9, 900, 9, 1'b1, 32'h8);   // full + pop: push dropped, pop done
        chk_head("R7", cw(1, 1, 0, 1), i1 >> 8, i1 & 255);
        ev(1'b0, 10, 1000, 10);                // refills to 8
        ev_wr(1'b0, 11, 1100, 11, 1'b1, 32'h2); // drop and clear together
        chk_head("R8", cw(1, 1, 0, 1), i1 >> 8, i1 & 255);
        pop_head();
        chk_head("R7", cw(1, 1, 1, 2), 200, 2); pop_head();
        chk_head("R7", cw(1, 1, 0, 2), i2 >> 8, i2 & 255); pop_head();
        chk_head("R7", cw(1, 1, 1, 3), 300, 3); pop_head();
        chk_head("R7", cw(1, 1, 0, 3), i3 >> 8, i3 & 255); pop_head();
        chk_head("R7", cw(1, 1, 0, 4), 400, 4); pop_head();
        chk_head("R7", cw(1, 1, 0, 6), 600, 6); pop_head();
        chk_head("R7", cw(1, 1, 0, 10), 1000, 10); pop_head();
        chk_head("R7", cw(0, 1, 0, 0), 0, 0);
        wr(2'd0, 32'h2);
        chk_head("R8", 32'h0, 0, 0);
    endtask

    task automatic t_id_wrap();
        logic [31:0] d;
        for (int k = 0; k < 4; k++) ev(1'b1, 0, 0, 0);
        while (next_id != 511) ev(1'b1, 1, 1, 1);
        wr(2'd0, 32'h2);
        for (int k = 0; k < 8; k++) pop_head();
        rd(2'd0, d);
        chk("R3", "drained after 8 pops", d, 32'h0);
        ev(1'b1, 20, 42, 0);
        pop_head();
        chk_head("R3", cw(1, 0, 0, 20), 1, 255);   // ID 511
        pop_head();
        ev(1'b1, 21, 43, 0);
        pop_head();
        chk_head("R3", cw(1, 0, 0, 21), 0, 0);     // ID wraps to 0
        pop_head();
        chk_head("R3", 32'h0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; ev_valid = 1'b0; ev_tx = 1'b0; ev_port = '0; ev_nsec = '0; ev_sub = '0;
        reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_egress();
        t_ingress();
        t_order();
        t_empty_and_ignored();
        t_capacity();
        t_id_wrap();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule